// File: doc/BRIEF.md
# Serial Programming Slave

This block lets an external programmer load and inspect a device's program memory and data memory through a three-wire serial link. The link has a serial clock, a data line into the block and a data line out of it. The block only listens while the device's reset input is held low. Every instruction is exactly four bytes long. Data is shifted most significant bit first. The block samples incoming bits on the rising serial clock edge and changes its outgoing bit on the falling edge. The serial pins are brought into the system clock domain and their edges are detected there, so the serial clock must be several times slower than the system clock.

A session starts with an enable handshake. Until that handshake is seen, every other instruction is dropped. During the third byte of any instruction the block sends back the second byte it received, so the programmer can confirm it is aligned on byte boundaries. Read results come back during the fourth byte.

After a write, the block reports a busy period of a set number of clocks. While that period lasts, reading the location being written returns a fixed marker value. A chip erase has a longer busy period. Two lock bits can block writes and reads. Only a chip erase clears the lock bits again. The two memories are modelled inside the block as register arrays.

Top module: `isp_slave`

## Requirements
- R1: The block shifts data in on each rising edge of `sck` and changes `miso` only on falling edges of `sck`, most significant bit first. `miso` is 0 out of reset and whenever `prog_rst_n` is high.
- R2: An instruction is four bytes. During bytes 1 and 2 the block returns 0x00. During byte 3 it returns the byte it received as byte 2. During byte 4 it returns the read result, or 0x00 for instructions that are not reads.
- R3: The enable instruction is 0xAC, 0x53, followed by two don't-care bytes, and it takes effect only while `prog_rst_n` is low. Before it is accepted, writes are dropped and reads return 0x00.
- R4: The program memory read is 0x20, x, address, x and returns the byte during byte 4. The program memory write is 0x40, x, address, data. The address is taken from the low bits of byte 3.
- R5: The data memory read is 0xA0, x, address, x and the data memory write is 0xC0, x, address, data. The data memory is a separate store from the program memory.
- R6: The identification read is 0x30, x, index, x. Index bits [1:0] equal to 0, 1 or 2 return the parameters SIG0, SIG1 and SIG2. Index 3 returns 0x00.
- R7: Chip erase is 0xAC, 0x80, x, x. It sets every location of both memories to 0xFF and returns both lock bits to 1.
- R8: The lock write is 0xAC, 0xE0, x, L. Each lock bit becomes lock AND L[1:0]. While lock bit 0 is 0, memory writes are dropped. While lock bit 1 is 0, every read returns 0x00. Only chip erase sets a lock bit back to 1.
- R9: A memory write starts a busy period of WR_TICKS clocks. During that period, a read of the same memory at the same address returns 0x7F, while other locations read normally. Any write, erase or lock write that arrives during a busy period is dropped.
- R10: A chip erase starts a busy period of ERASE_TICKS clocks, which is longer than WR_TICKS. Commands that arrive after WR_TICKS but before ERASE_TICKS are still dropped.
- R11: Driving `prog_rst_n` high discards any partly received instruction and clears the enabled state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low block reset |
| prog_rst_n | input | 1 | Device reset input; programming is active while this is low |
| sck | input | 1 | Serial clock from the programmer |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block |

## Verification
The bench writes and reads back every program memory address and every data memory address. Each address gets a different arithmetic pattern, so an address decoding fault or a mix-up between the two memories shows up as a wrong byte. Polling reads are placed at three points: right after a write, at a neighbouring address, and in the other memory. Together these separate the marker value from data being returned too late. Writes are issued inside the short busy window and inside the longer erase-only window, which shows whether the two busy lengths are really different. Lock, abort and pre-enable sequences are each followed by read-backs through the serial link, which show whether the dropped command left anything changed.

// File: rtl/isp_pkg.sv
package isp_pkg;
    // First-byte opcodes
    localparam logic [7:0] OP_PRE  = 8'hAC;  // enable / erase / lock group
    localparam logic [7:0] OP_RD_P = 8'h20;
    localparam logic [7:0] OP_WR_P = 8'h40;
    localparam logic [7:0] OP_RD_D = 8'hA0;
    localparam logic [7:0] OP_WR_D = 8'hC0;
    localparam logic [7:0] OP_SIG  = 8'h30;
    // Second-byte qualifiers in the OP_PRE group
    localparam logic [7:0] SUB_EN    = 8'h53;
    localparam logic [7:0] SUB_ERASE = 8'h80;
    localparam logic [7:0] SUB_LOCK  = 8'hE0;
endpackage

// File: rtl/isp_sync.sv
module isp_sync #(
    parameter int              W       = 1,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q, s2_q, s1_d, s2_d;

    always_comb begin
        s1_d = d;
        s2_d = s1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= RST_VAL;
            s2_q <= RST_VAL;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/isp_shift.sv
module isp_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       sck_s,
    input  logic       mosi_s,
    input  logic [7:0] tx_val,
    output logic       byte_done,
    output logic [7:0] byte_val,
    output logic [1:0] byte_idx,
    output logic       miso
);
    typedef struct packed {
        logic       sck_prev;
        logic [6:0] sh;
        logic [2:0] bitc;
        logic [1:0] idx;
        logic [7:0] tx;
        logic       miso;
    } sh_t;

    sh_t q, n;
    logic rise, fall;

    always_comb begin
        rise      = sck_s & ~q.sck_prev;
        fall      = ~sck_s & q.sck_prev;
        byte_val  = {q.sh, mosi_s};
        byte_done = active & rise & (q.bitc == 3'd7);
        byte_idx  = q.idx;

        n          = q;
        n.sck_prev = sck_s;
        if (!active) begin
            n.sh   = '0;
            n.bitc = '0;
            n.idx  = '0;
            n.tx   = '0;
            n.miso = 1'b0;
        end else begin
            if (rise) begin
                n.sh   = {q.sh[5:0], mosi_s};
                n.bitc = q.bitc + 3'd1;
                if (q.bitc == 3'd7) begin
                    n.idx = q.idx + 2'd1;
                    n.tx  = tx_val;
                end
            end
            if (fall) begin
                n.miso = q.tx[7];
                n.tx   = {q.tx[6:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign miso = q.miso;

    // R1
    miso_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.miso != $past(q.miso)) |-> ($past(fall) || $past(!active)));
endmodule

// File: rtl/isp_store.sv
module isp_store #(
    parameter int         PM_AW       = 6,
    parameter int         DM_AW       = 5,
    parameter int         WR_TICKS    = 4000,
    parameter int         ERASE_TICKS = 8000,
    parameter logic [7:0] POLL_MARK   = 8'h7F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_p,
    input  logic             wr_d,
    input  logic             erase,
    input  logic             lock_wr,
    input  logic [PM_AW-1:0] p_waddr,
    input  logic [DM_AW-1:0] d_waddr,
    input  logic [7:0]       wdata,
    input  logic [PM_AW-1:0] p_raddr,
    input  logic [DM_AW-1:0] d_raddr,
    output logic [7:0]       p_rdata,
    output logic [7:0]       d_rdata,
    output logic [1:0]       lock
);
    localparam int PM_DEPTH = 1 << PM_AW;
    localparam int DM_DEPTH = 1 << DM_AW;
    localparam int CW       = $clog2(ERASE_TICKS + 1);

    typedef struct packed {
        logic [CW-1:0]    cnt;
        logic             poll;
        logic             sel;   // 0 program, 1 data
        logic [PM_AW-1:0] pa;
        logic [DM_AW-1:0] da;
        logic [1:0]       lock;
    } st_t;

    st_t        q, n;
    logic [7:0] pm_q [PM_DEPTH];
    logic [7:0] pm_d [PM_DEPTH];
    logic [7:0] dm_q [DM_DEPTH];
    logic [7:0] dm_d [DM_DEPTH];
    logic       idle;

    always_comb begin
        idle = (q.cnt == '0);
        n    = q;
        pm_d = pm_q;
        dm_d = dm_q;
        if (!idle) n.cnt = q.cnt - 1'b1;
        if (idle) begin
            if (erase) begin
                for (int i = 0; i < PM_DEPTH; i++) pm_d[i] = 8'hFF;
                for (int i = 0; i < DM_DEPTH; i++) dm_d[i] = 8'hFF;
                n.lock = 2'b11;
                n.cnt  = CW'(ERASE_TICKS);
                n.poll = 1'b0;
            end else if (wr_p) begin
                pm_d[p_waddr] = wdata;
                n.cnt  = CW'(WR_TICKS);
                n.poll = 1'b1;
                n.sel  = 1'b0;
                n.pa   = p_waddr;
            end else if (wr_d) begin
                dm_d[d_waddr] = wdata;
                n.cnt  = CW'(WR_TICKS);
                n.poll = 1'b1;
                n.sel  = 1'b1;
                n.da   = d_waddr;
            end else if (lock_wr) begin
                n.lock = q.lock & wdata[1:0];
            end
        end
        p_rdata = (!idle && q.poll && !q.sel && q.pa == p_raddr) ? POLL_MARK : pm_q[p_raddr];
        d_rdata = (!idle && q.poll &&  q.sel && q.da == d_raddr) ? POLL_MARK : dm_q[d_raddr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.lock <= 2'b11;
            for (int i = 0; i < PM_DEPTH; i++) pm_q[i] <= 8'hFF;
            for (int i = 0; i < DM_DEPTH; i++) dm_q[i] <= 8'hFF;
        end else begin
            q    <= n;
            pm_q <= pm_d;
            dm_q <= dm_d;
        end
    end

    assign lock = q.lock;

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && (wr_p || wr_d)) |=> ($stable(q.pa) && $stable(q.da) && $stable(q.sel)));
    // R8
    lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(q.lock & ~$past(q.lock))) |-> $past(erase));
    // R10
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(ERASE_TICKS));
endmodule

// File: rtl/isp_slave.sv
module isp_slave
    import isp_pkg::*;
#(
    parameter int         PM_AW       = 6,
    parameter int         DM_AW       = 5,
    parameter int         WR_TICKS    = 4000,
    parameter int         ERASE_TICKS = 8000,
    parameter logic [7:0] POLL_MARK   = 8'h7F,
    parameter logic [7:0] SIG0        = 8'h5A,
    parameter logic [7:0] SIG1        = 8'h21,
    parameter logic [7:0] SIG2        = 8'h07
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_rst_n,
    input  logic sck,
    input  logic mosi,
    output logic miso
);
    localparam int AW = (PM_AW > DM_AW) ? PM_AW : DM_AW;

    typedef struct packed {
        logic [7:0]    b1;
        logic [7:0]    b2;
        logic [AW-1:0] b3;
        logic          en;
    } dec_t;

    dec_t       q, n;
    logic [2:0] pins_s;
    logic       active, byte_done;
    logic [7:0] byte_val, tx_val, p_rdata, d_rdata;
    logic [1:0] byte_idx, lock;
    logic       wr_p, wr_d, erase, lock_wr;

    isp_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({prog_rst_n, sck, mosi}), .q(pins_s));

    assign active = ~pins_s[2];

    isp_shift u_shift (
        .clk(clk), .rst_n(rst_n), .active(active), .sck_s(pins_s[1]), .mosi_s(pins_s[0]),
        .tx_val(tx_val), .byte_done(byte_done), .byte_val(byte_val),
        .byte_idx(byte_idx), .miso(miso));

    isp_store #(.PM_AW(PM_AW), .DM_AW(DM_AW), .WR_TICKS(WR_TICKS),
                .ERASE_TICKS(ERASE_TICKS), .POLL_MARK(POLL_MARK)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_p(wr_p), .wr_d(wr_d), .erase(erase), .lock_wr(lock_wr),
        .p_waddr(q.b3[PM_AW-1:0]), .d_waddr(q.b3[DM_AW-1:0]), .wdata(byte_val),
        .p_raddr(byte_val[PM_AW-1:0]), .d_raddr(byte_val[DM_AW-1:0]),
        .p_rdata(p_rdata), .d_rdata(d_rdata), .lock(lock));

    always_comb begin
        n       = q;
        tx_val  = 8'h00;
        wr_p    = 1'b0;
        wr_d    = 1'b0;
        erase   = 1'b0;
        lock_wr = 1'b0;
        if (!active) begin
            n = '0;
        end else if (byte_done) begin
            unique case (byte_idx)
                2'd0: n.b1 = byte_val;
                2'd1: begin
                    n.b2   = byte_val;
                    tx_val = byte_val;          // echo during byte 3
                end
                2'd2: begin
                    n.b3 = byte_val[AW-1:0];
                    if (q.en && lock[1]) begin
                        unique case (q.b1)
                            OP_RD_P: tx_val = p_rdata;
                            OP_RD_D: tx_val = d_rdata;
                            OP_SIG: begin
                                unique case (byte_val[1:0])
                                    2'd0:    tx_val = SIG0;
                                    2'd1:    tx_val = SIG1;
                                    2'd2:    tx_val = SIG2;
                                    default: tx_val = 8'h00;
                                endcase
                            end
                            default: tx_val = 8'h00;
                        endcase
                    end
                end
                default: begin
                    if (q.b1 == OP_PRE && q.b2 == SUB_EN) begin
                        n.en = 1'b1;
                    end else if (q.en) begin
                        erase   = (q.b1 == OP_PRE) && (q.b2 == SUB_ERASE);
                        lock_wr = (q.b1 == OP_PRE) && (q.b2 == SUB_LOCK);
                        wr_p    = (q.b1 == OP_WR_P) && lock[0];
                        wr_d    = (q.b1 == OP_WR_D) && lock[0];
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    // R3
    en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.en) |-> $past(byte_done && byte_idx == 2'd3 && q.b1 == OP_PRE && q.b2 == SUB_EN));
    // R11
    drop_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !q.en);
endmodule

// File: tb/test_isp_slave.sv
`timescale 1ns/1ps
module test_isp_slave;
    localparam int PM_AW = 5;
    localparam int DM_AW = 4;
    localparam int WRT   = 800;
    localparam int ERT   = 1600;
    localparam int HALF  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prog_rst_n = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic miso;

    int checks = 0;
    int errors = 0;
    logic [7:0] pm [1 << PM_AW];
    logic [7:0] dm [1 << DM_AW];

    always #4 clk = ~clk;

    isp_slave #(.PM_AW(PM_AW), .DM_AW(DM_AW), .WR_TICKS(WRT), .ERASE_TICKS(ERT),
                .POLL_MARK(8'h7F), .SIG0(8'h5A), .SIG1(8'h21), .SIG2(8'h07)) i_isp_slave (
        .clk(clk), .rst_n(rst_n), .prog_rst_n(prog_rst_n), .sck(sck), .mosi(mosi), .miso(miso));

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            sck  = 1'b0;
            mosi = tx[i];
            waitc(HALF);
            rx[i] = miso;
            sck  = 1'b1;
            waitc(HALF);
        end
    endtask

    task automatic xfer(input logic [7:0] b1, b2, b3, b4,
                        output logic [7:0] r1, r2, r3, r4);
        xbyte(b1, r1);
        xbyte(b2, r2);
        xbyte(b3, r3);
        xbyte(b4, r4);
        sck = 1'b0;
        waitc(HALF);
    endtask

    task automatic cmd(input logic [7:0] b1, b2, b3, b4);
        logic [7:0] r1, r2, r3, r4;
        xfer(b1, b2, b3, b4, r1, r2, r3, r4);
    endtask

    task automatic rd(input logic [7:0] op, input logic [7:0] a, output logic [7:0] v);
        logic [7:0] r1, r2, r3;
        xfer(op, 8'h00, a, 8'h00, r1, r2, r3, v);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%02h expected=%02h", 8'h00, 8'h01);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] r1, r2, r3, r4, v;
        for (int i = 0; i < (1 << PM_AW); i++) pm[i] = 8'hFF;
        for (int i = 0; i < (1 << DM_AW); i++) dm[i] = 8'hFF;
        waitc(5);
        rst_n = 1'b1;
        waitc(5);
        chk("R1 reset miso", {7'd0, miso}, 8'h00);
        prog_rst_n = 1'b0;
        waitc(10);

        // R3 before enable: read returns zero, write dropped; R2 echo and zero bytes
        xfer(8'h20, 8'h5C, 8'h03, 8'h00, r1, r2, r3, r4);
        chk("R2 byte1 zero", r1, 8'h00);
        chk("R2 byte2 zero", r2, 8'h00);
        chk("R2 echo", r3, 8'h5C);
        chk("R3 read before enable", r4, 8'h00);
        cmd(8'h40, 8'h00, 8'h03, 8'hAA);
        waitc(WRT + 100);

        xfer(8'hAC, 8'h53, 8'h00, 8'h00, r1, r2, r3, r4);
        chk("R3 enable echo", r3, 8'h53);
        chk("R2 non-read byte4", r4, 8'h00);
        rd(8'h20, 8'h03, v);
        chk("R3 write before enable dropped", v, 8'hFF);

        // R4 program memory sweep
        for (int a = 0; a < (1 << PM_AW); a++) begin
            pm[a] = 8'((a * 29 + 7) & 8'hFF);
            cmd(8'h40, 8'h00, 8'(a), pm[a]);
            waitc(WRT + 100);
        end
        // R5 data memory sweep
        for (int a = 0; a < (1 << DM_AW); a++) begin
            dm[a] = 8'((a * 53 + 17) ^ 8'h5A);
            cmd(8'hC0, 8'h00, 8'(a), dm[a]);
            waitc(WRT + 100);
        end
        for (int a = 0; a < (1 << PM_AW); a++) begin
            rd(8'h20, 8'(a), v);
            chk($sformatf("R4 pmem[%0d]", a), v, pm[a]);
        end
        for (int a = 0; a < (1 << DM_AW); a++) begin
            rd(8'hA0, 8'(a), v);
            chk($sformatf("R5 dmem[%0d]", a), v, dm[a]);
        end

        // R6 identification bytes
        rd(8'h30, 8'h00, v); chk("R6 sig0", v, 8'h5A);
        rd(8'h30, 8'h01, v); chk("R6 sig1", v, 8'h21);
        rd(8'h30, 8'h02, v); chk("R6 sig2", v, 8'h07);
        rd(8'h30, 8'h03, v); chk("R6 sig3", v, 8'h00);

        // R9 polling marker and busy drop
        cmd(8'h40, 8'h00, 8'h05, 8'h3C);
        pm[5] = 8'h3C;
        rd(8'h20, 8'h05, v); chk("R9 poll marker", v, 8'h7F);
        rd(8'h20, 8'h06, v); chk("R9 other address", v, pm[6]);
        rd(8'hA0, 8'h05, v); chk("R9 other memory", v, dm[5]);
        waitc(WRT + 100);
        rd(8'h20, 8'h05, v); chk("R9 after busy", v, 8'h3C);
        cmd(8'h40, 8'h00, 8'h07, 8'h11);
        pm[7] = 8'h11;
        cmd(8'h40, 8'h00, 8'h08, 8'h22);   // lands in busy window
        waitc(WRT + 100);
        rd(8'h20, 8'h07, v); chk("R9 first write", v, 8'h11);
        rd(8'h20, 8'h08, v); chk("R9 write in busy dropped", v, pm[8]);

        // R7 / R10 erase
        cmd(8'hAC, 8'h80, 8'h00, 8'h00);
        waitc(WRT + 100);                  // past write window, inside erase window
        cmd(8'h40, 8'h00, 8'h02, 8'h44);
        waitc(ERT + 100);
        for (int i = 0; i < (1 << PM_AW); i++) pm[i] = 8'hFF;
        for (int i = 0; i < (1 << DM_AW); i++) dm[i] = 8'hFF;
        rd(8'h20, 8'h02, v); chk("R10 write in erase window dropped", v, 8'hFF);
        rd(8'h20, 8'h01, v); chk("R7 pmem erased", v, 8'hFF);
        rd(8'hA0, 8'h03, v); chk("R7 dmem erased", v, 8'hFF);

        // R8 lock bits
        cmd(8'hAC, 8'hE0, 8'h00, 8'hFE);
        cmd(8'h40, 8'h00, 8'h04, 8'h99);
        waitc(WRT + 100);
        rd(8'h20, 8'h04, v); chk("R8 write lock", v, 8'hFF);
        cmd(8'hAC, 8'hE0, 8'h00, 8'hFD);
        rd(8'h20, 8'h04, v); chk("R8 read lock", v, 8'h00);
        rd(8'h30, 8'h00, v); chk("R8 read lock sig", v, 8'h00);
        cmd(8'hAC, 8'hE0, 8'h00, 8'hFF);
        rd(8'h20, 8'h04, v); chk("R8 lock not undone", v, 8'h00);
        cmd(8'hAC, 8'h80, 8'h00, 8'h00);
        waitc(ERT + 100);
        rd(8'h20, 8'h04, v); chk("R7 erase restores read", v, 8'hFF);
        cmd(8'h40, 8'h00, 8'h04, 8'h12);
        waitc(WRT + 100);
        rd(8'h20, 8'h04, v); chk("R7 erase restores write", v, 8'h12);

        // R11 abort of partial instruction clears enable
        xbyte(8'hAC, r1);
        xbyte(8'h53, r2);
        sck = 1'b0;
        waitc(HALF);
        prog_rst_n = 1'b1;
        waitc(20);
        chk("R1 miso idle while released", {7'd0, miso}, 8'h00);
        prog_rst_n = 1'b0;
        waitc(20);
        cmd(8'h40, 8'h00, 8'h09, 8'h77);
        waitc(WRT + 100);
        xfer(8'hAC, 8'h53, 8'h00, 8'h00, r1, r2, r3, r4);
        chk("R11 realigned echo", r3, 8'h53);
        rd(8'h20, 8'h09, v); chk("R11 enable cleared", v, 8'hFF);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule